// File: doc/BRIEF.md
# Pipelined Burst SRAM Front End

This block is a synthesizable model of a synchronous burst SRAM with a small internal array. On every rising clock edge it captures the address, a chip enable, two address strobes, a burst advance input and the write controls. The two strobes are a processor-side strobe, which always starts a read, and a controller-side strobe, which starts a read or a write as the write inputs decide. Once a burst has started, later cycles with both strobes idle either step a 2-bit burst counter or hold it. The counter runs in linear or interleaved order.

Writes can cover single bytes or the whole word. Read data passes through an input register stage and an output register, so it leaves the block one edge later than the edge that captured the read. The data bus is a driven value plus an enable, which feed a tri-state pad. After a deselect, the enable turns off after either one edge or two, as a mode input selects. An asynchronous output enable and a sleep input complete the control set. In sleep the array keeps its contents and the block ignores every other input.

Top module: `burst_sram`

## Requirements
- R1: With chip enable low (ce_n=0) and the processor strobe low (adsp_n=0), a burst starts at the external address as a read, even when the write inputs request a write. The array is not changed.
- R2: With adsp_n=1, adsc_n=0 and ce_n=0, a burst starts at the external address. It is a write or a read as decided by R6. Write data on dq_in is sampled on the same edge as the command.
- R3: adsc_n=0 with ce_n=1 is a deselect. It ends the burst, and dq_oe turns off with the timing given in R9.
- R4: When a burst is active and adsp_n=1 and adsc_n=1, adv_n=0 steps the burst counter and adv_n=1 keeps the current address. Either cycle is a read or a write as decided by R6.
- R5: The low two address bits of access i in a burst that starts at low bits s are (s+i) mod 4 when order_sel=0 (linear) and s XOR i when order_sel=1 (interleaved). The upper bits stay fixed. The fifth access returns to s.
- R6: Byte lane i is dq bits [9i+8:9i]. With gw_n=0, all lanes are written. Otherwise, with bwe_n=0, a lane is written exactly when bsel_n[i]=0. Any other combination, including bwe_n=0 with every bsel_n bit high, is a read of the full word.
- R7: When an edge captures a write command, dq_oe is low after that edge. This applies even if a read is still in the pipeline.
- R8: The data of a read captured at edge k appears on dq_out with dq_oe high after edge k+1, not after edge k. Back-to-back reads deliver one word per cycle.
- R9: With dual_desel=0, dq_oe is low right after the edge that captures a deselect. With dual_desel=1, the read captured one edge before the deselect is still shown after the deselect edge, and dq_oe is low after the next edge.
- R10: oe_n=1 forces dq_oe low at once, without a clock edge. A read taken with oe_n=1 still steps the burst counter.
- R11: sleep sampled high on two edges puts the block to sleep. In sleep, dq_oe is low, commands are ignored and the array keeps its contents. After sleep is sampled low, the first two edges are still ignored.
- R12: After reset, dq_oe is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address, AW = log2(DEPTH) |
| ce_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Lane-select write enable, active low |
| bsel_n | input | NB | Per-lane write select, active low |
| order_sel | input | 1 | 0 linear, 1 interleaved burst order |
| dual_desel | input | 1 | 0 single-cycle, 1 dual-cycle deselect |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| dq_in | input | NB*LW | Write data from the pad |
| dq_out | output | NB*LW | Read data to the pad |
| dq_oe | output | 1 | Pad driver enable |

## Verification
The collision that matters most is a deselect or a write command captured on the same edge at which the previous read's data is due to leave the pipeline. The bench provokes it by issuing a read and then a deselect or a write on the very next edge, in both deselect modes. It judges the result from dq_oe and dq_out, sampled just after that edge and just after the one that follows. A second overlap, a dummy read whose counter step lands in the same cycle as oe_n being high, is checked by the address that the next visible word comes from.

// File: rtl/burst_sram_pkg.sv
// Shared types and the burst order function for the burst SRAM front end.
// Assumes a 2-bit burst counter; callers pass start bits and count.
package burst_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_DESEL = 2'd3
    } op_e;

    // Low address bits of a burst access: linear add or interleaved XOR.
    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] cnt,
                                            input logic       il);
        return il ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/burst_sram_ctl.sv
// Command decoder, burst counter, sleep synchroniser and input register
// stage. Assumes AW >= 3 (two burst bits plus at least one upper bit).
// Produces the decoded command of the current edge (comb) and the
// registered stage-1 command that the array and drivers act upon.
module burst_sram_ctl
    import burst_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 8,
    parameter int DW = 72
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          adv_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bsel_n,
    input  logic          order_sel,
    input  logic          sleep,
    input  logic [DW-1:0] dq_in,
    output op_e           cmd_op,
    output op_e           s1_op,
    output logic [AW-1:0] s1_addr,
    output logic [NB-1:0] s1_mask,
    output logic [DW-1:0] s1_data,
    output logic          asleep
);

    localparam int HW = AW - 2;

    logic [1:0]    slp_q;
    logic [HW-1:0] b_hi;
    logic [1:0]    b_start;
    logic [1:0]    b_cnt;
    logic          b_act;

    logic          awake;
    logic          start_p;
    logic          start_c;
    logic          desel;
    logic          cont;
    logic [NB-1:0] wmask;
    logic [1:0]    cnt_nx;
    logic [AW-1:0] acc_addr;
    logic [NB-1:0] cmd_mask;

    assign asleep = slp_q[1];

    // Two-stage sleep request pipeline; stage two is the sleep state.
    always_ff @(posedge clk) begin
        if (!rst_n) slp_q <= 2'b00;
        else        slp_q <= {slp_q[0], sleep};
    end

    // Decode the strobes, enables and write controls of this edge.
    always_comb begin
        awake   = ~asleep;
        start_p = awake & ~ce_n & ~adsp_n;
        start_c = awake & ~ce_n & adsp_n & ~adsc_n;
        desel   = awake & ce_n & ~adsc_n;
        cont    = awake & ~start_p & ~start_c & ~desel & b_act;
        if (!gw_n)       wmask = '1;
        else if (!bwe_n) wmask = ~bsel_n;
        else             wmask = '0;
        cnt_nx  = adv_n ? b_cnt : b_cnt + 2'd1;
        if (start_p || start_c) acc_addr = addr;
        else                    acc_addr = {b_hi, burst_lo(b_start, cnt_nx, order_sel)};
        if (start_p)               cmd_op = OP_READ;
        else if (start_c || cont)  cmd_op = (|wmask) ? OP_WRITE : OP_READ;
        else if (desel)            cmd_op = OP_DESEL;
        else                       cmd_op = OP_IDLE;
        cmd_mask = (cmd_op == OP_WRITE) ? wmask : '0;
    end

    // Burst state: load on a start, clear on deselect, step on continue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_hi    <= '0;
            b_start <= 2'b00;
            b_cnt   <= 2'b00;
            b_act   <= 1'b0;
        end else if (start_p || start_c) begin
            b_hi    <= addr[AW-1:2];
            b_start <= addr[1:0];
            b_cnt   <= 2'b00;
            b_act   <= 1'b1;
        end else if (desel) begin
            b_act   <= 1'b0;
        end else if (cont) begin
            b_cnt   <= cnt_nx;
        end
    end

    // Input register stage holding the command for the array edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op   <= OP_IDLE;
            s1_addr <= '0;
            s1_mask <= '0;
            s1_data <= '0;
        end else begin
            s1_op   <= cmd_op;
            s1_addr <= acc_addr;
            s1_mask <= cmd_mask;
            s1_data <= dq_in;
        end
    end

endmodule

// File: rtl/burst_sram_array.sv
// Byte-lane storage array with a registered read port. One memory per
// lane so each lane writes independently. Assumes DEPTH is 2**AW.
// The array itself is not reset; the read register is.
module burst_sram_array #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int NB    = 8,
    parameter int LW    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [NB-1:0]    mask,
    input  logic [NB*LW-1:0] wdata,
    output logic [NB*LW-1:0] rdata
);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        // Lane write when the lane is selected in the write mask.
        always_ff @(posedge clk) begin
            if (wr_en && mask[g]) mem[addr] <= wdata[g*LW +: LW];
        end

        // Lane read into the output data register.
        always_ff @(posedge clk) begin
            if (!rst_n)     rdata[g*LW +: LW] <= '0;
            else if (rd_en) rdata[g*LW +: LW] <= mem[addr];
        end
    end

endmodule

// File: rtl/burst_sram_drv.sv
// Output driver enable. The enable register follows the read pipeline.
// A write captured at an edge clears it at once. So does a deselect in
// single-cycle mode. Output enable and sleep gate it without a clock.
module burst_sram_drv
    import burst_sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  op_e  cmd_op,
    input  op_e  s1_op,
    input  logic dual_desel,
    input  logic oe_n,
    input  logic asleep,
    output logic dq_oe
);

    logic drv_q;

    // Registered drive state: early cut on write or single-cycle deselect.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drv_q <= 1'b0;
        else if (cmd_op == OP_WRITE || (cmd_op == OP_DESEL && !dual_desel))
            drv_q <= 1'b0;
        else
            drv_q <= (s1_op == OP_READ);
    end

    assign dq_oe = drv_q & ~oe_n & ~asleep;

endmodule

// File: rtl/burst_sram.sv
// Top of the pipelined burst SRAM front end: decoder and input stage,
// lane array and driver enable. The pad buffer lies outside; it drives
// dq_out when dq_oe is high.
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NB    = 8,
    parameter int LW    = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = NB * LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          adv_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bsel_n,
    input  logic          order_sel,
    input  logic          dual_desel,
    input  logic          oe_n,
    input  logic          sleep,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);

    op_e           cmd_op;
    op_e           s1_op;
    logic [AW-1:0] s1_addr;
    logic [NB-1:0] s1_mask;
    logic [DW-1:0] s1_data;
    logic          asleep;

    burst_sram_ctl #(.AW(AW), .NB(NB), .DW(DW)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .ce_n      (ce_n),
        .adsp_n    (adsp_n),
        .adsc_n    (adsc_n),
        .adv_n     (adv_n),
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .bsel_n    (bsel_n),
        .order_sel (order_sel),
        .sleep     (sleep),
        .dq_in     (dq_in),
        .cmd_op    (cmd_op),
        .s1_op     (s1_op),
        .s1_addr   (s1_addr),
        .s1_mask   (s1_mask),
        .s1_data   (s1_data),
        .asleep    (asleep)
    );

    burst_sram_array #(.DEPTH(DEPTH), .AW(AW), .NB(NB), .LW(LW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (s1_op == OP_WRITE),
        .rd_en (s1_op == OP_READ),
        .addr  (s1_addr),
        .mask  (s1_mask),
        .wdata (s1_data),
        .rdata (dq_out)
    );

    burst_sram_drv u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_op     (cmd_op),
        .s1_op      (s1_op),
        .dual_desel (dual_desel),
        .oe_n       (oe_n),
        .asleep     (asleep),
        .dq_oe      (dq_oe)
    );

endmodule

// File: rtl/burst_sram_chk.sv
// Temporal checks on the burst SRAM top, attached through bind.
module burst_sram_chk
    import burst_sram_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic adsp_n,
    input logic adsc_n,
    input logic gw_n,
    input logic dual_desel,
    input logic sleep,
    input logic asleep,
    input op_e  s1_op,
    input logic dq_oe
);

    // R1
    adsp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && !ce_n && !adsp_n) |=> (s1_op == OP_READ));

    // R3
    desel_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && ce_n && !adsc_n) |=> (s1_op == OP_DESEL));

    // R7
    write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && !ce_n && adsp_n && !adsc_n && !gw_n) |=> !dq_oe);

    // R9
    scd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && ce_n && !adsc_n && !dual_desel) |=> !dq_oe);

    // R9
    dcd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && ce_n && !adsc_n && dual_desel) |=> ##1 !dq_oe);

    // R11
    sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && $past(sleep)) |=> !dq_oe);

endmodule

bind burst_sram burst_sram_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .adsp_n     (adsp_n),
    .adsc_n     (adsc_n),
    .gw_n       (gw_n),
    .dual_desel (dual_desel),
    .sleep      (sleep),
    .asleep     (asleep),
    .s1_op      (s1_op),
    .dq_oe      (dq_oe)
);

// File: tb/burst_sram_tb.sv
// Self-checking bench for burst_sram with a 16-word array.
module burst_sram_tb;

    localparam int DEPTH = 16;
    localparam int NB    = 8;
    localparam int LW    = 9;
    localparam int AW    = 4;
    localparam int DW    = NB * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n;
    logic [NB-1:0] bsel_n;
    logic          order_sel, dual_desel, oe_n, sleep;
    logic [DW-1:0] dq_in;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    logic [DW-1:0] exp_mem [DEPTH];
    int            n_chk = 0;
    int            n_err = 0;
    bit            done  = 1'b0;

    always #5 clk = ~clk;

    burst_sram #(.DEPTH(DEPTH), .NB(NB), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bsel_n(bsel_n), .order_sel(order_sel),
        .dual_desel(dual_desel), .oe_n(oe_n), .sleep(sleep),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [DW-1:0] pat(input int a, input int seed);
        logic [DW-1:0] r;
        for (int i = 0; i < NB; i++)
            r[i*LW +: LW] = LW'((a * 37 + seed * 11 + i * 53 + 5) % 512);
        return r;
    endfunction

    function automatic int bidx(input int base, input int s, input int i, input bit il);
        return base + (il ? ((s ^ i) & 3) : ((s + i) & 3));
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic in_idle();
        ce_n = 1'b1; adsp_n = 1'b1; adsc_n = 1'b0; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bsel_n = '1;
    endtask

    task automatic in_rd(input int a);
        ce_n = 1'b0; adsp_n = 1'b1; adsc_n = 1'b0; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bsel_n = '1; addr = AW'(a);
    endtask

    task automatic in_wr(input int a, input logic [DW-1:0] d, input logic g,
                         input logic b, input logic [NB-1:0] bs);
        ce_n = 1'b0; adsp_n = 1'b1; adsc_n = 1'b0; adv_n = 1'b1;
        gw_n = g; bwe_n = b; bsel_n = bs; addr = AW'(a); dq_in = d;
    endtask

    task automatic in_cont(input logic adv, input logic g, input logic [DW-1:0] d);
        ce_n = 1'b1; adsp_n = 1'b1; adsc_n = 1'b1; adv_n = adv;
        gw_n = g; bwe_n = 1'b1; bsel_n = '1; dq_in = d;
    endtask

    task automatic model_wr(input int a, input logic [DW-1:0] d, input logic g,
                            input logic b, input logic [NB-1:0] bs);
        for (int i = 0; i < NB; i++)
            if (!g || (!b && !bs[i])) exp_mem[a][i*LW +: LW] = d[i*LW +: LW];
    endtask

    task automatic read_chk(input int a, input string tag);
        in_rd(a);
        step();
        in_idle();
        step();
        check({tag, " oe"}, DW'(dq_oe), DW'(1));
        check({tag, " data"}, dq_out, exp_mem[a]);
        step();
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; dq_in = '0; oe_n = 1'b0; sleep = 1'b0;
        order_sel = 1'b0; dual_desel = 1'b1;
        in_idle();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R12 reset oe", DW'(dq_oe), DW'(0));

        // R2 fill by global writes, then R8 read latency and read back
        for (int a = 0; a < DEPTH; a++) begin
            in_wr(a, pat(a, 1), 1'b0, 1'b1, '1);
            step();
            model_wr(a, pat(a, 1), 1'b0, 1'b1, '1);
        end
        in_rd(3);
        step();
        check("R8 not yet driven", DW'(dq_oe), DW'(0));
        in_idle();
        step();
        check("R8 one edge later", dq_out, exp_mem[3]);
        step();
        for (int a = 0; a < DEPTH; a++) read_chk(a, "R2 fill readback");

        // R6 byte-mask sweep over every lane select pattern
        for (int m = 0; m < 256; m++) begin
            in_wr(m % DEPTH, pat(m, 3), 1'b1, 1'b0, ~NB'(m));
            step();
            model_wr(m % DEPTH, pat(m, 3), 1'b1, 1'b0, ~NB'(m));
            in_idle();
            step();
            read_chk(m % DEPTH, "R6 lane mask");
        end
        // R6 bwe_n high makes the lane selects a read
        in_wr(5, pat(99, 9), 1'b1, 1'b1, '0);
        step();
        in_idle();
        step();
        read_chk(5, "R6 bwe high no write");

        // R5 burst order, R1 forced read via processor strobe
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 4; s++) begin
                order_sel = o[0];
                ce_n = 1'b0; adsp_n = 1'b0; adsc_n = 1'b1; adv_n = 1'b1;
                gw_n = 1'b0; bwe_n = 1'b1; bsel_n = '1;
                addr = AW'(8 + s); dq_in = pat(77, 7);
                step();
                for (int i = 1; i <= 4; i++) begin
                    in_cont(1'b0, 1'b1, '0);
                    step();
                    check($sformatf("R5 order %0d start %0d access %0d", o, s, i - 1),
                          dq_out, exp_mem[bidx(8, s, i - 1, o[0])]);
                end
                in_idle();
                step();
                check($sformatf("R1 R5 wrap order %0d start %0d", o, s),
                      dq_out, exp_mem[8 + s]);
                step();
            end
        end
        order_sel = 1'b0;

        // R4 suspend: start 1, advance, hold, advance
        in_rd(5);
        step();
        in_cont(1'b0, 1'b1, '0); step();
        check("R4 start", dq_out, exp_mem[5]);
        in_cont(1'b1, 1'b1, '0); step();
        check("R4 advance", dq_out, exp_mem[6]);
        in_cont(1'b0, 1'b1, '0); step();
        check("R4 suspend holds", dq_out, exp_mem[6]);
        in_idle(); step();
        check("R4 advance after hold", dq_out, exp_mem[7]);
        step();

        // R4 burst write with interleaved order from low bits 2
        order_sel = 1'b1;
        in_wr(10, pat(200, 2), 1'b0, 1'b1, '1); step();
        model_wr(10, pat(200, 2), 1'b0, 1'b1, '1);
        in_cont(1'b0, 1'b0, pat(201, 2)); step();
        model_wr(11, pat(201, 2), 1'b0, 1'b1, '1);
        in_cont(1'b0, 1'b0, pat(202, 2)); step();
        model_wr(8, pat(202, 2), 1'b0, 1'b1, '1);
        in_idle(); step();
        order_sel = 1'b0;
        read_chk(10, "R4 burst write 0");
        read_chk(11, "R4 burst write 1");
        read_chk(8, "R4 burst write 2");
        read_chk(9, "R4 burst write untouched");

        // R10 dummy read advances the counter; oe_n acts without a clock
        in_rd(12); step();
        oe_n = 1'b1;
        in_cont(1'b0, 1'b1, '0); step();
        check("R10 oe_n high blocks drive", DW'(dq_oe), DW'(0));
        oe_n = 1'b0;
        #1;
        check("R10 oe_n low drives at once", DW'(dq_oe), DW'(1));
        in_cont(1'b0, 1'b1, '0); step();
        check("R10 dummy read data", dq_out, exp_mem[13]);
        oe_n = 1'b1;
        #1;
        check("R10 async off", DW'(dq_oe), DW'(0));
        oe_n = 1'b0;
        in_idle(); step();
        check("R10 counter advanced", dq_out, exp_mem[14]);
        step();

        // R9 dual-cycle deselect, R3 deselect ends drive
        dual_desel = 1'b1;
        in_rd(1); step();
        in_rd(2); step();
        check("R8 back-to-back first", dq_out, exp_mem[1]);
        in_idle(); step();
        check("R9 dual shows last read oe", DW'(dq_oe), DW'(1));
        check("R9 dual shows last read", dq_out, exp_mem[2]);
        step();
        check("R3 R9 dual off after second edge", DW'(dq_oe), DW'(0));

        // R9 single-cycle deselect
        dual_desel = 1'b0;
        in_rd(3); step();
        in_rd(4); step();
        check("R9 single back-to-back oe", DW'(dq_oe), DW'(1));
        check("R9 single back-to-back", dq_out, exp_mem[3]);
        in_idle(); step();
        check("R9 single off at once", DW'(dq_oe), DW'(0));
        step();
        dual_desel = 1'b1;

        // R7 a write right after a read cuts the drive
        in_rd(6); step();
        in_wr(7, pat(300, 4), 1'b0, 1'b1, '1); step();
        model_wr(7, pat(300, 4), 1'b0, 1'b1, '1);
        check("R7 write edge drive off", DW'(dq_oe), DW'(0));
        in_idle(); step();
        read_chk(7, "R7 write landed");

        // R11 sleep: drive off, commands ignored, contents kept
        in_idle();
        sleep = 1'b1;
        step(); step();
        in_wr(9, pat(400, 5), 1'b0, 1'b1, '1); step();
        in_rd(9); step(); step();
        check("R11 asleep drive off", DW'(dq_oe), DW'(0));
        sleep = 1'b0;
        in_wr(9, pat(401, 5), 1'b0, 1'b1, '1); step(); step();
        in_idle(); step(); step();
        read_chk(9, "R11 contents kept");
        read_chk(8, "R11 neighbour kept");

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog R12 got %0d exp %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule